// File: doc/BRIEF.md
# Sequenced Sample Buffer Controller

This block is the digital data path of a multichannel sampler that runs on its own in a monitoring mode. A programmable conversion timer paces conversions, and a round-robin sequencer picks which enabled channel each conversion belongs to. On every conversion the block raises a strobe and presents the channel index to a stand-in converter port. The converter answers in the same cycle with a sample and a good/bad indication.

The sample is packed into a buffer word. The word can carry the channel number and a validity bit if desired. The word is then pushed into a 16-entry first-in first-out store, and a host drains that store through a show-ahead read port.

The store has two write policies. A fill policy stops accepting words when the store is full. A ring policy accepts words only between a start trigger and a stop trigger, and when full it discards the oldest entry to make room. The current fill count is an output at all times, so it can be read while a sequence is running.

Top module: `sbc_top`

## Requirements
- R1: The store holds up to 16 words of 16 bits; `rd_data` always shows the oldest stored word, and pulsing `rd_en` removes it, so words leave in the order they were written.
- R2: `fill_count` equals the number of stored words at all times, is 0 after reset, and stays unchanged in a cycle where one word is read and one is written.
- R3: While the store is empty, `rd_data` is 0 and `rd_en` leaves `fill_count` at 0.
- R4: While `run` is 1 and `chan_mask` is non-zero, `conv_strobe` pulses once every N cycles, where N = `conv_clocks` (a setting of 0 acts as 1). The first pulse comes N cycles after the block becomes active. No pulse occurs while `run` is 0.
- R5: Successive conversions visit the enabled channels in ascending index order and wrap from the highest enabled channel to the lowest. Each new activation starts at the lowest enabled channel, so a channel recurs every k·N cycles for k enabled channels.
- R6: With `chan_mask` all zeros the block makes no conversions and writes nothing.
- R7: A stored word holds the 12-bit sample in bits 15:4. Bits 3:1 hold the channel index if `tag_chan` is 1 and are 0 otherwise. Bit 0 holds `conv_ok` if `tag_valid` is 1 and is 0 otherwise. With both tags off, the word is the sample shifted left by four with zero fill.
- R8: With `buf_mode` = 0 (fill policy), a conversion is stored only if the store is not full before that cycle's read, so the count stops at 16.
- R9: With `buf_mode` = 1 (ring policy), conversions are stored only after a `trig_start` pulse and before a `trig_stop` pulse; if both come in the same cycle, stop wins. A write into a full store with no read discards the oldest word and keeps the count at 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_mask | input | 8 | Enabled channels, bit i enables channel i |
| conv_clocks | input | 16 | Clocks per conversion cycle (0 treated as 1) |
| run | input | 1 | Sequencer enable |
| buf_mode | input | 1 | 0 fill policy, 1 ring policy |
| trig_start | input | 1 | Arms writes in ring policy |
| trig_stop | input | 1 | Disarms writes in ring policy |
| tag_chan | input | 1 | Put channel index into bits 3:1 |
| tag_valid | input | 1 | Put converter status into bit 0 |
| conv_strobe | output | 1 | A conversion happens this cycle |
| conv_chan | output | 3 | Channel of the current conversion |
| conv_data | input | 12 | Sample from the stand-in converter |
| conv_ok | input | 1 | Converter result is good |
| rd_en | input | 1 | Remove the oldest word |
| rd_data | output | 16 | Oldest stored word, 0 when empty |
| fill_count | output | 5 | Number of stored words |

## Verification
The bench compares the design against a queue-based model on every clock and targets the following corner cases:
- Conversion settings of 0 and 1. A timer that mishandles these would skip or double pulses.
- A sparse channel mask with wrap-around. A wrong sequencer would repeat a channel or start from a stale index after a restart.
- A full store with and without a read in the same cycle, under both policies. A wrong overwrite path would let the count pass 16, lose the newest word instead of the oldest, or change the count on a read-plus-write.
- Reads of an empty store, tag combinations with alternating converter status, and a long random stretch that changes mask, mode and triggers mid-run.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   typedef enum logic {
      POLICY_FILL = 1'b0,
      POLICY_RING = 1'b1
   } buf_policy_e;
endpackage

// File: rtl/sbc_pacer.sv
module sbc_pacer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [TMR_W-1:0] conv_clocks,
   output logic             fire
);
   logic [TMR_W-1:0] tmr;
   logic [TMR_W-1:0] limit;

   assign limit = (conv_clocks == '0) ? '0 : conv_clocks - 1'b1;
   assign fire  = active && (tmr >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           tmr <= '0;
      else if (!active)     tmr <= '0;
      else if (fire)        tmr <= '0;
      else                  tmr <= tmr + 1'b1;
   end
endmodule

// File: rtl/sbc_sequencer.sv
module sbc_sequencer #(
   parameter int CH_NUM = 8,
   localparam int CH_W = $clog2(CH_NUM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              fire,
   input  logic [CH_NUM-1:0] chan_mask,
   output logic [CH_W-1:0]   chan
);
   logic [CH_W-1:0]   last;
   logic [CH_NUM-1:0] above;

   // channels strictly above the last one converted
   for (genvar g = 0; g < CH_NUM; g++) begin : g_above
      assign above[g] = chan_mask[g] && (g > int'(last));
   end

   always_comb begin
      logic hit;
      hit  = 1'b0;
      chan = '0;
      for (int i = 0; i < CH_NUM; i++) begin
         if (!hit && above[i]) begin
            chan = CH_W'(i);
            hit  = 1'b1;
         end
      end
      for (int i = 0; i < CH_NUM; i++) begin
         if (!hit && chan_mask[i]) begin
            chan = CH_W'(i);
            hit  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       last <= CH_W'(CH_NUM - 1);
      else if (!active) last <= CH_W'(CH_NUM - 1);
      else if (fire)    last <= chan;
   end
endmodule

// File: rtl/sbc_fifo.sv
module sbc_fifo #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ring,
   input  logic              push,
   input  logic              pop_req,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout,
   output logic [CNT_W-1:0]  count
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  head, tail;
   logic              full, empty, pop, wr, drop, adv;

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
   assign pop   = pop_req && !empty;
   assign wr    = ring ? push : (push && !full);
   assign drop  = ring && push && full && !pop;
   assign adv   = pop || drop;
   assign dout  = empty ? '0 : mem[head];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          mem[g] <= '0;
         else if (wr && tail == PTR_W'(g))    mem[g] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (adv) head <= head + 1'b1;
         if (wr)  tail <= tail + 1'b1;
         if (wr && !adv)      count <= count + 1'b1;
         else if (!wr && adv) count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/sbc_top.sv
module sbc_top #(
   parameter int CH_NUM   = 8,
   parameter int SAMPLE_W = 12,
   parameter int WORD_W   = 16,
   parameter int DEPTH    = 16,
   parameter int TMR_W    = 16,
   localparam int CH_W    = $clog2(CH_NUM),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CH_NUM-1:0]   chan_mask,
   input  logic [TMR_W-1:0]    conv_clocks,
   input  logic                run,
   input  logic                buf_mode,
   input  logic                trig_start,
   input  logic                trig_stop,
   input  logic                tag_chan,
   input  logic                tag_valid,
   output logic                conv_strobe,
   output logic [CH_W-1:0]     conv_chan,
   input  logic [SAMPLE_W-1:0] conv_data,
   input  logic                conv_ok,
   input  logic                rd_en,
   output logic [WORD_W-1:0]   rd_data,
   output logic [CNT_W-1:0]    fill_count
);
   import sbc_pkg::*;

   if (CH_NUM < 2) begin : g_bad_ch
      $error("sbc_top: CH_NUM must be at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sbc_top: DEPTH must be a power of two >= 2");
   end
   if (WORD_W < SAMPLE_W + CH_W + 1) begin : g_bad_word
      $error("sbc_top: WORD_W too narrow for sample plus tags");
   end

   buf_policy_e       policy;
   logic              active, fire, armed, push;
   logic [WORD_W-1:0] word;

   assign policy      = buf_policy_e'(buf_mode);
   assign active      = run && (chan_mask != '0);
   assign conv_strobe = fire;

   sbc_pacer #(.TMR_W(TMR_W)) i_pacer (
      .clk(clk), .rst_n(rst_n), .active(active),
      .conv_clocks(conv_clocks), .fire(fire)
   );

   sbc_sequencer #(.CH_NUM(CH_NUM)) i_seq (
      .clk(clk), .rst_n(rst_n), .active(active), .fire(fire),
      .chan_mask(chan_mask), .chan(conv_chan)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          armed <= 1'b0;
      else if (trig_stop)  armed <= 1'b0;
      else if (trig_start) armed <= 1'b1;
   end

   always_comb begin
      word = '0;
      word[WORD_W-1 -: SAMPLE_W] = conv_data;
      if (tag_chan)  word[CH_W:1] = conv_chan;
      if (tag_valid) word[0]      = conv_ok;
   end

   assign push = fire && ((policy == POLICY_FILL) || armed);

   sbc_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n), .ring(policy == POLICY_RING),
      .push(push), .pop_req(rd_en), .din(word),
      .dout(rd_data), .count(fill_count)
   );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
   parameter int CH_NUM = 8,
   parameter int WORD_W = 16,
   parameter int DEPTH  = 16,
   localparam int CH_W  = $clog2(CH_NUM),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CH_NUM-1:0] chan_mask,
   input logic              run,
   input logic              buf_mode,
   input logic              rd_en,
   input logic              conv_strobe,
   input logic [CH_W-1:0]   conv_chan,
   input logic [WORD_W-1:0] rd_data,
   input logic [CNT_W-1:0]  fill_count
);
   a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fill_count) <= DEPTH);

   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (int'(fill_count) <= int'($past(fill_count)) + 1) &&
               (int'(fill_count) + 1 >= int'($past(fill_count))));

   a_r3_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count == '0 |-> rd_data == '0);

   a_r3_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_count == '0) && rd_en && !conv_strobe |=> fill_count == '0);

   a_r4_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !conv_strobe);

   a_r5_chan_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      conv_strobe |-> chan_mask[conv_chan]);

   a_r6_mask_idle: assert property (@(posedge clk) disable iff (!rst_n)
      chan_mask == '0 |-> !conv_strobe);

   a_r8_fill_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_mode && (int'(fill_count) == DEPTH) && !rd_en |=> int'(fill_count) == DEPTH);

   a_r9_ring_full: assert property (@(posedge clk) disable iff (!rst_n)
      buf_mode && (int'(fill_count) == DEPTH) && !rd_en |=> int'(fill_count) == DEPTH);
endmodule

bind sbc_top sbc_checker #(.CH_NUM(CH_NUM), .WORD_W(WORD_W), .DEPTH(DEPTH)) i_chk (
   .clk(clk), .rst_n(rst_n), .chan_mask(chan_mask), .run(run),
   .buf_mode(buf_mode), .rd_en(rd_en), .conv_strobe(conv_strobe),
   .conv_chan(conv_chan), .rd_data(rd_data), .fill_count(fill_count)
);

// File: tb/test_sbc_top.sv
module test_sbc_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;
   localparam int DEP = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  chan_mask = '0;
   logic [15:0] conv_clocks = 16'd1;
   logic        run = 1'b0, buf_mode = 1'b0, trig_start = 1'b0, trig_stop = 1'b0;
   logic        tag_chan = 1'b0, tag_valid = 1'b0;
   logic        conv_strobe;
   logic [2:0]  conv_chan;
   logic [11:0] conv_data = '0;
   logic        conv_ok = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] rd_data;
   logic [4:0]  fill_count;

   sbc_top i_sbc_top (
      .clk(clk), .rst_n(rst_n), .chan_mask(chan_mask), .conv_clocks(conv_clocks),
      .run(run), .buf_mode(buf_mode), .trig_start(trig_start), .trig_stop(trig_stop),
      .tag_chan(tag_chan), .tag_valid(tag_valid), .conv_strobe(conv_strobe),
      .conv_chan(conv_chan), .conv_data(conv_data), .conv_ok(conv_ok),
      .rd_en(rd_en), .rd_data(rd_data), .fill_count(fill_count)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0, cyc = 0;
   string req = "R2";
   bit ok_alt = 1'b0;

   // behavioural reference
   int m_tmr = 0, m_last = NCH - 1;
   bit m_armed = 1'b0;
   logic [15:0] q[$];

   task automatic check(input bit good, input string r, input string what,
                        input int act, input int exp);
      checks++;
      if (!good) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", r, what, act, exp, cyc);
      end
   endtask

   function automatic int next_chan(input logic [7:0] m, input int last);
      for (int k = 1; k <= NCH; k++) begin
         int idx;
         idx = (last + k) % NCH;
         if (m[idx]) return idx;
      end
      return 0;
   endfunction

   task automatic tick();
      bit act, fire, wr, pop;
      int lim, ch, sz;
      logic [15:0] w;
      conv_data = 12'((cyc * 37 + 5) & 12'hFFF);
      conv_ok   = ok_alt ? (cyc % 2 == 1) : 1'b1;
      #2;
      act  = run && (chan_mask != 0);
      lim  = (conv_clocks == 0) ? 0 : int'(conv_clocks) - 1;
      fire = act && (m_tmr >= lim);
      ch   = next_chan(chan_mask, m_last);
      sz   = q.size();
      check(conv_strobe == fire, (chan_mask == 0) ? "R6" : "R4", "strobe", int'(conv_strobe), int'(fire));
      if (fire) check(int'(conv_chan) == ch, "R5", "channel", int'(conv_chan), ch);
      check(int'(fill_count) == sz, req, "fill_count", int'(fill_count), sz);
      if (sz == 0) check(rd_data == 16'h0, "R3", "empty rd_data", int'(rd_data), 0);
      else         check(rd_data == q[0], req, "rd_data", int'(rd_data), int'(q[0]));
      // next state
      w = {conv_data, 4'h0};
      if (tag_chan)  w[3:1] = 3'(ch);
      if (tag_valid) w[0]   = conv_ok;
      pop = rd_en && (sz > 0);
      wr  = buf_mode ? (fire && m_armed) : (fire && sz < DEP);
      if (pop) void'(q.pop_front());
      if (wr) begin
         if (q.size() == DEP) void'(q.pop_front());
         q.push_back(w);
      end
      if (trig_stop) m_armed = 1'b0; else if (trig_start) m_armed = 1'b1;
      if (!act)      begin m_tmr = 0; m_last = NCH - 1; end
      else if (fire) begin m_tmr = 0; m_last = ch; end
      else           m_tmr++;
      @(posedge clk);
      #1;
      cyc++;
   endtask

   task automatic run_cycles(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R2: reset state
      check(fill_count == 0, "R2", "reset count", int'(fill_count), 0);
      check(rd_data == 0, "R2", "reset rd_data", int'(rd_data), 0);
      check(conv_strobe == 0, "R2", "reset strobe", int'(conv_strobe), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R6: empty mask, running
      req = "R6"; run = 1; chan_mask = 8'h00; conv_clocks = 3;
      run_cycles(20);

      // R4/R5: sparse mask, tags on, pacing 3
      req = "R5"; chan_mask = 8'b1010_0101; tag_chan = 1; tag_valid = 1;
      run_cycles(30);
      run = 0; run_cycles(4);
      req = "R4"; run = 1; conv_clocks = 0; chan_mask = 8'b0100_0010;
      run_cycles(4);
      run = 0;
      // R1: drain in order, then R3: read empty
      req = "R1"; rd_en = 1; run_cycles(20);
      req = "R3"; run_cycles(5); rd_en = 0;

      // R8: fill policy to full, pace 1
      req = "R8"; buf_mode = 0; chan_mask = 8'hFF; conv_clocks = 1; run = 1;
      run_cycles(30);
      rd_en = 1; run_cycles(1); rd_en = 0; run_cycles(3);
      // R2: read and write every cycle at partial fill
      run = 0; rd_en = 1; run_cycles(8);
      req = "R2"; run = 1; run_cycles(20); rd_en = 0; run = 0;
      rd_en = 1; run_cycles(20); rd_en = 0;

      // R7: tag combinations with alternating status
      req = "R7"; ok_alt = 1; chan_mask = 8'b0011_1000; conv_clocks = 2; run = 1;
      tag_chan = 0; tag_valid = 1; run_cycles(6);
      tag_chan = 1; tag_valid = 0; run_cycles(6);
      tag_chan = 0; tag_valid = 0; run_cycles(6);
      run = 0; rd_en = 1; run_cycles(12); rd_en = 0;

      // R9: ring policy, unarmed then armed with overwrite, then stopped
      req = "R9"; buf_mode = 1; tag_chan = 1; tag_valid = 1; chan_mask = 8'h11;
      conv_clocks = 2; run = 1; run_cycles(10);
      trig_start = 1; run_cycles(1); trig_start = 0;
      run_cycles(50);
      rd_en = 1; run_cycles(3); rd_en = 0;
      trig_start = 1; trig_stop = 1; run_cycles(1); trig_start = 0; trig_stop = 0;
      run_cycles(10);
      run = 0; rd_en = 1; run_cycles(20); rd_en = 0;

      // mixed random stretch
      req = "R2";
      for (int i = 0; i < 600; i++) begin
         if (i % 50 == 0) begin
            chan_mask   = 8'($urandom);
            conv_clocks = 16'($urandom_range(0, 4));
            buf_mode    = 1'($urandom);
            tag_chan    = 1'($urandom);
            tag_valid   = 1'($urandom);
         end
         run        = ($urandom_range(0, 9) != 0);
         rd_en      = ($urandom_range(0, 2) == 0);
         trig_start = ($urandom_range(0, 19) == 0);
         trig_stop  = ($urandom_range(0, 29) == 0);
         tick();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule